// File: doc/BRIEF.md
# Per-Channel Test Symbol Scheduler

This block decides, independently for each of two channels, whether a media access test symbol is requested in the symbol window of the current communication cycle. Each channel has a host-written enable bit, a 6-bit cycle mask and a 6-bit cycle value. The block reads the enable bit when the static segment ends, so arming is committed one cycle ahead. At the next cycle-start strobe it compares the masked cycle counter with the masked value. When the symbol-window strobe arrives in a selected cycle, it raises a one-clock request on that channel.

Each channel runs a four-state machine. ST_IDLE means nothing is armed and nothing is pending. ST_ARMED means armed for the coming cycle. ST_PEND means selected for the current cycle. ST_PEND_ARMED means selected now and also armed for the next cycle. The transitions are: cycle start, which goes to ST_PEND on an armed match and to ST_IDLE otherwise; static end, which sets or clears the armed part from the enable; and symbol window, which moves ST_PEND to ST_IDLE or ST_PEND_ARMED to ST_ARMED while emitting the request. When strobes coincide, cycle start wins over static end, and static end wins over symbol window. A symbol-window strobe that loses to another strobe produces no request.

Top module: `test_symbol_sched`

## Requirements
- R1: After reset no channel is armed, so the first cycle after reset produces no request, and the request outputs are low during reset.
- R2: The enable bit is sampled in the clock where the static-segment indicator falls from 1 to 0. That value alone decides whether the channel is armed for the following cycle. Changes of the enable at any other time have no effect on the outcome.
- R3: If the enable is 0 at the end of the static segment of cycle N-1, no request is produced in cycle N, whatever the match result.
- R4: An armed cycle N is selected when (cycle counter AND mask) equals (value AND mask). The comparison uses the 6-bit counter presented with the cycle-start strobe of cycle N. A mask of zero selects every cycle.
- R5: The request is high exactly in the clock where the symbol-window strobe is high in a selected cycle. It lasts one clock and fires at most once per cycle, so a second window strobe in the same cycle gives no request.
- R6: The channels are evaluated independently. Channel i uses enable bit i, and mask and value bits [i*6 +: 6]. Both channels may request in the same cycle.
- R7: A selection that is not consumed by a symbol window is dropped at the next cycle start. It never carries into a later, non-matching cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_cnt | input | 6 | Current communication cycle number, valid with cyc_start |
| static_seg | input | 1 | High during the static segment |
| cyc_start | input | 1 | One-clock strobe at the start of each cycle |
| sym_win | input | 1 | One-clock strobe at the start of the symbol window |
| cfg_en | input | 2 | Per-channel enable, bit i for channel i |
| cfg_mask | input | 12 | Per-channel cycle mask, channel i at [i*6 +: 6] |
| cfg_val | input | 12 | Per-channel cycle value, channel i at [i*6 +: 6] |
| sym_req | output | 2 | Per-channel one-clock test symbol request |

## Verification
A wrong state in a channel machine shows at the ports no later than the next symbol-window strobe. A lost arm shows as a missing request. A stale pending selection shows as a request in a cycle whose counter does not match, or as a second request in one cycle. The bench sweeps all 64 counter values under several mask and value pairs. It toggles the enable in a fixed pattern and flips it right after each static end, so a fault in sampling, masking or consuming changes a request within one cycle.

// File: rtl/tsym_pkg.sv
package tsym_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ARMED      = 2'd1,
        ST_PEND       = 2'd2,
        ST_PEND_ARMED = 2'd3
    } tsym_state_e;
endpackage

// File: rtl/tsym_match.sv
module tsym_match #(
    parameter int CYC_W = 6
) (
    input  logic [CYC_W-1:0] cnt,
    input  logic [CYC_W-1:0] mask,
    input  logic [CYC_W-1:0] val,
    output logic             hit
);
    // Bits outside the mask are don't-care.
    always_comb begin
        hit = (((cnt ^ val) & mask) == '0);
    end
endmodule

// File: rtl/tsym_chan.sv
module tsym_chan
    import tsym_pkg::*;
#(
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CYC_W-1:0] mask,
    input  logic [CYC_W-1:0] val,
    input  logic [CYC_W-1:0] cnt,
    input  logic             cyc_start,
    input  logic             static_end,
    input  logic             sym_win,
    output logic             req
);
    tsym_state_e state, state_nx;
    logic        hit;
    logic        armed;
    logic        pend;

    tsym_match #(.CYC_W(CYC_W)) u_match (
        .cnt  (cnt),
        .mask (mask),
        .val  (val),
        .hit  (hit)
    );

    assign armed = (state == ST_ARMED) || (state == ST_PEND_ARMED);
    assign pend  = (state == ST_PEND)  || (state == ST_PEND_ARMED);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: cycle start > static end > symbol window
    always_comb begin
        state_nx = state;
        if (cyc_start) begin
            state_nx = (armed && hit) ? ST_PEND : ST_IDLE;
        end else if (static_end) begin
            unique case (state)
                ST_IDLE, ST_ARMED:      state_nx = en ? ST_ARMED      : ST_IDLE;
                ST_PEND, ST_PEND_ARMED: state_nx = en ? ST_PEND_ARMED : ST_PEND;
                default:                state_nx = ST_IDLE;
            endcase
        end else if (sym_win) begin
            unique case (state)
                ST_PEND:       state_nx = ST_IDLE;
                ST_PEND_ARMED: state_nx = ST_ARMED;
                default:       state_nx = state;
            endcase
        end
    end

    // Output decode
    always_comb begin
        req = 1'b0;
        if (sym_win && !cyc_start && !static_end) begin
            unique case (state)
                ST_PEND, ST_PEND_ARMED: req = 1'b1;
                default:                req = 1'b0;
            endcase
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    a_r5_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (state == ST_IDLE || state == ST_ARMED));
    a_r4_select: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && armed && hit) |=> (state == ST_PEND));
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !(armed && hit)) |=> (state == ST_IDLE));
    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && static_end && en) |=> (state == ST_ARMED || state == ST_PEND_ARMED));
    a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && static_end && !en) |=> (state == ST_IDLE || state == ST_PEND));
endmodule

// File: rtl/test_symbol_sched.sv
module test_symbol_sched #(
    parameter int CYC_W  = 6,
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CYC_W-1:0]        cyc_cnt,
    input  logic                    static_seg,
    input  logic                    cyc_start,
    input  logic                    sym_win,
    input  logic [NUM_CH-1:0]       cfg_en,
    input  logic [NUM_CH*CYC_W-1:0] cfg_mask,
    input  logic [NUM_CH*CYC_W-1:0] cfg_val,
    output logic [NUM_CH-1:0]       sym_req
);
    localparam int CFG_W = NUM_CH * CYC_W;

    logic static_q;
    logic static_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) static_q <= 1'b0;
        else        static_q <= static_seg;
    end

    assign static_end = static_q && !static_seg;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tsym_chan #(.CYC_W(CYC_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (cfg_en[ch]),
            .mask       (cfg_mask[ch*CYC_W +: CYC_W]),
            .val        (cfg_val[ch*CYC_W +: CYC_W]),
            .cnt        (cyc_cnt),
            .cyc_start  (cyc_start),
            .static_end (static_end),
            .sym_win    (sym_win),
            .req        (sym_req[ch])
        );
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (sym_req == '0));
    a_r5_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_req != '0) |-> (sym_win && !cyc_start));
    a_r2_edge_seen: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(static_seg) |-> (sym_req == '0));
    initial assert (CFG_W == NUM_CH * CYC_W);
endmodule

// File: tb/sim_test_symbol_sched.sv
module sim_test_symbol_sched;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 6;
    localparam int NC = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [W-1:0]    cyc_cnt = '0;
    logic            static_seg = 1'b0;
    logic            cyc_start = 1'b0;
    logic            sym_win = 1'b0;
    logic [NC-1:0]   cfg_en = '0;
    logic [NC*W-1:0] cfg_mask = '0;
    logic [NC*W-1:0] cfg_val = '0;
    logic [NC-1:0]   sym_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [NC-1:0] prev_arm = '0;
    bit first_cycle = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    test_symbol_sched #(.CYC_W(W), .NUM_CH(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_cnt(cyc_cnt), .static_seg(static_seg),
        .cyc_start(cyc_start), .sym_win(sym_win), .cfg_en(cfg_en),
        .cfg_mask(cfg_mask), .cfg_val(cfg_val), .sym_req(sym_req)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic sel(logic [W-1:0] c, logic [W-1:0] m, logic [W-1:0] v);
        return (c & m) == (v & m);
    endfunction

    // One cycle: start, static segment, static end, enable flip, two windows.
    task automatic run_cycle(logic [W-1:0] cnt, logic [NC-1:0] want, bit do_sym);
        logic [NC-1:0] exp;
        for (int ch = 0; ch < NC; ch++)
            exp[ch] = prev_arm[ch] && sel(cnt, cfg_mask[ch*W +: W], cfg_val[ch*W +: W]);
        @(negedge clk); cyc_start = 1'b1; cyc_cnt = cnt;
        @(negedge clk); cyc_start = 1'b0; static_seg = 1'b1; cfg_en = want;
        @(negedge clk);
        @(negedge clk); static_seg = 1'b0;
        @(negedge clk); cfg_en = ~want;
        @(negedge clk);
        if (do_sym) begin
            sym_win = 1'b1; #1;
            for (int ch = 0; ch < NC; ch++) begin
                if (first_cycle)      check("R1", sym_req[ch], exp[ch]);
                else if (ch == 1)     check("R6", sym_req[ch], exp[ch]);
                else if (!prev_arm[ch]) check("R3", sym_req[ch], exp[ch]);
                else if (!exp[ch])    check("R4", sym_req[ch], exp[ch]);
                else                  check("R2", sym_req[ch], exp[ch]);
            end
            @(negedge clk); sym_win = 1'b0;
            @(negedge clk); sym_win = 1'b1; #1;
            for (int ch = 0; ch < NC; ch++) check("R5", sym_req[ch], 1'b0);
            @(negedge clk); sym_win = 1'b0;
        end
        prev_arm = want;
        first_cycle = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] masks_a [4] = '{6'h00, 6'h3F, 6'h07, 6'h30};
        logic [W-1:0] vals_a  [4] = '{6'h15, 6'h05, 6'h03, 6'h20};
        logic [W-1:0] masks_b [4] = '{6'h3F, 6'h00, 6'h38, 6'h01};
        logic [W-1:0] vals_b  [4] = '{6'h2A, 6'h00, 6'h08, 6'h01};
        repeat (3) @(negedge clk);
        for (int ch = 0; ch < NC; ch++) check("R1", sym_req[ch], 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cfg_mask = {masks_b[k], masks_a[k]};
            cfg_val  = {vals_b[k], vals_a[k]};
            for (int i = 0; i < 64; i++) begin
                logic [NC-1:0] w;
                w[0] = ((i + k) % 5) != 3;
                w[1] = ((i + 2*k) % 7) != 2;
                run_cycle(W'(i), w, 1'b1);
            end
        end
        // R7: selected cycle without a window, then a non-matching armed cycle.
        cfg_mask = {6'h3F, 6'h3F};
        cfg_val  = {6'h10, 6'h10};
        run_cycle(6'h0F, 2'b11, 1'b1);
        run_cycle(6'h10, 2'b11, 1'b0);
        @(negedge clk); cyc_start = 1'b1; cyc_cnt = 6'h11;
        @(negedge clk); cyc_start = 1'b0;
        @(negedge clk); sym_win = 1'b1; #1;
        for (int ch = 0; ch < NC; ch++) check("R7", sym_req[ch], 1'b0);
        @(negedge clk); sym_win = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule